// File: doc/BRIEF.md
# Parallel ADC Conversion Sequencer

This block runs a parallel-output analog-to-digital converter from the synchronous side of a chip. It drives the converter's active-low chip select, sample/hold and read strobes and a two-bit input select, and it watches the converter's active-low end-of-conversion interrupt. Each conversion is requested through a valid/ready command port that carries the input number and the handshake mode. The captured data word leaves through a valid/ready result port, tagged with the input it came from.

Two handshake modes share the same pins. In split mode the sequencer lowers sample/hold for a fixed sampling window and then raises it. It waits for the interrupt and then gives a separate read pulse, and the data is taken during that pulse. In tied mode sample/hold and read fall and rise together as one strobe. The data bus still shows the previous result until the interrupt falls, so the word is taken only after the interrupt is seen. The interrupt passes through a two-flop synchroniser. If it does not fall within a set number of cycles, the attempt is abandoned with an error pulse. Every interval is a cycle-count parameter.

Top module: `adc_host_ctrl`

## Requirements
- R1: After synchronous reset, `adc_cs_n`, `adc_sh_n` and `adc_rd_n` are high, `res_valid` and `err_timeout` are low, and `cmd_ready` is high.
- R2: `adc_sh_n` and `adc_rd_n` are only ever low while `adc_cs_n` is low.
- R3: `adc_sel` carries the binary input number from `cmd_chan` (0 to 3). It is driven, with `adc_cs_n` low, at least SETUP_CYC cycles before `adc_sh_n` falls, and it does not change while `adc_cs_n` stays low.
- R4: In split mode (`cmd_mode` = 0), `adc_sh_n` is low for exactly SH_LOW_CYC cycles, and `adc_rd_n` stays high during that window.
- R5: In split mode, `adc_rd_n` falls only after the interrupt has been seen low. It stays low for exactly RD_LOW_CYC cycles, and the result word is the bus value at the end of that pulse.
- R6: In tied mode (`cmd_mode` = 1), `adc_sh_n` and `adc_rd_n` fall in the same cycle and rise in the same cycle. The bus is not taken before the interrupt falls, so the result is the new conversion and not the earlier value on the bus.
- R7: A result raises `res_valid` with `res_data` and `res_chan` = the requested input. All three stay unchanged until `res_ready` is high, and `cmd_ready` stays low while `res_valid` is high.
- R8: If the interrupt has not fallen TIMEOUT_CYC cycles after the waiting phase starts, `err_timeout` pulses for one cycle, all strobes return high and no result is produced.
- R9: After the strobes are released, chip select does not fall again for at least GAP_CYC cycles, nor until the synchronised interrupt is high.
- R10: The interrupt takes effect on the third rising clock edge after it falls. In split mode that is the edge where `adc_rd_n` falls; in tied mode it is the edge where `res_valid` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Conversion request |
| cmd_ready | output | 1 | Request accepted when high together with cmd_valid |
| cmd_chan | input | SEL_W | Input number to convert |
| cmd_mode | input | 1 | 0 = split strobes, 1 = tied strobe |
| res_valid | output | 1 | Result word available |
| res_ready | input | 1 | Consumer takes the result |
| res_data | output | DATA_W | Converted word |
| res_chan | output | SEL_W | Input number the word belongs to |
| err_timeout | output | 1 | One-cycle pulse when the interrupt never came |
| adc_cs_n | output | 1 | Converter chip select, active low |
| adc_sh_n | output | 1 | Converter sample/hold, active low |
| adc_rd_n | output | 1 | Converter read, active low |
| adc_sel | output | SEL_W | Converter input select |
| adc_int_n | input | 1 | Converter end-of-conversion, active low, asynchronous |
| adc_data | input | DATA_W | Converter data bus |

## Verification
The interrupt is asynchronous, so the important latency is three edges from its fall to the reaction: two synchroniser edges and one registered output. The bench records the cycle of each pin event and checks split-mode read fall and tied-mode result valid at exactly interrupt fall plus three. Sampling width and read width are checked as exact differences between fall and rise cycles. Setup time and the inter-conversion gap are checked as lower bounds. The timeout pulse is expected exactly TIMEOUT_CYC cycles after the waiting phase begins. All events are observed on the falling clock edge, half a cycle after the registers update.

// File: rtl/adc_host_pkg.sv
package adc_host_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_SAMPLE,
    ST_WAIT,
    ST_READ,
    ST_GAP
  } ctrl_state_t;

  typedef enum logic {
    MODE_SPLIT = 1'b0,
    MODE_TIED  = 1'b1
  } conv_mode_t;

  function automatic int max2(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_sync_chain.sv
module adc_sync_chain #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] stage;

  genvar i;
  generate
    for (i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stage[0] <= RST_VAL;
          else     stage[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stage[i] <= RST_VAL;
          else     stage[i] <= stage[i-1];
        end
      end
    end
  endgenerate

  assign q = stage[STAGES-1];
endmodule

// File: rtl/adc_cycle_timer.sv
module adc_cycle_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         done
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)             cnt <= '0;
    else if (load)       cnt <= load_val;
    else if (cnt != '0)  cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);
endmodule

// File: rtl/adc_result_slot.sv
module adc_result_slot #(
  parameter int DATA_W = 10,
  parameter int SEL_W  = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic [SEL_W-1:0]  load_chan,
  input  logic              ready,
  output logic              valid,
  output logic [DATA_W-1:0] data,
  output logic [SEL_W-1:0]  chan
);
  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      data  <= '0;
      chan  <= '0;
    end else if (load) begin
      valid <= 1'b1;
      data  <= load_data;
      chan  <= load_chan;
    end else if (valid && ready) begin
      valid <= 1'b0;
    end
  end
endmodule

// File: rtl/adc_host_ctrl.sv
module adc_host_ctrl
  import adc_host_pkg::*;
#(
  parameter int DATA_W      = 10,
  parameter int SEL_W       = 2,
  parameter int SETUP_CYC   = 2,
  parameter int SH_LOW_CYC  = 25,
  parameter int RD_LOW_CYC  = 3,
  parameter int TIMEOUT_CYC = 200,
  parameter int GAP_CYC     = 5,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [SEL_W-1:0]  cmd_chan,
  input  logic              cmd_mode,
  output logic              res_valid,
  input  logic              res_ready,
  output logic [DATA_W-1:0] res_data,
  output logic [SEL_W-1:0]  res_chan,
  output logic              err_timeout,
  output logic              adc_cs_n,
  output logic              adc_sh_n,
  output logic              adc_rd_n,
  output logic [SEL_W-1:0]  adc_sel,
  input  logic              adc_int_n,
  input  logic [DATA_W-1:0] adc_data
);
  localparam int MAX_CYC = max2(max2(max2(SETUP_CYC, SH_LOW_CYC),
                                     max2(RD_LOW_CYC, TIMEOUT_CYC)), GAP_CYC);
  localparam int TMR_W = $clog2(MAX_CYC + 1);
  localparam logic [TMR_W-1:0] LD_SETUP = TMR_W'(SETUP_CYC);
  localparam logic [TMR_W-1:0] LD_SHLOW = TMR_W'(SH_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_RDLOW = TMR_W'(RD_LOW_CYC - 1);
  localparam logic [TMR_W-1:0] LD_TMO   = TMR_W'(TIMEOUT_CYC - 1);
  localparam logic [TMR_W-1:0] LD_GAP   = TMR_W'(GAP_CYC);

  ctrl_state_t      st_q, st_d;
  conv_mode_t       mode_q, mode_d;
  logic             cs_q, cs_d, sh_q, sh_d, rd_q, rd_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             err_q, err_d;
  logic             int_s;
  logic             tmr_load, tmr_done;
  logic [TMR_W-1:0] tmr_val;
  logic             res_load;

  adc_sync_chain #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_int_sync (
    .clk (clk),
    .rst (rst),
    .d   (adc_int_n),
    .q   (int_s)
  );

  adc_cycle_timer #(.W(TMR_W)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  adc_result_slot #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_slot (
    .clk       (clk),
    .rst       (rst),
    .load      (res_load),
    .load_data (adc_data),
    .load_chan (sel_q),
    .ready     (res_ready),
    .valid     (res_valid),
    .data      (res_data),
    .chan      (res_chan)
  );

  assign cmd_ready = (st_q == ST_IDLE) && !res_valid;

  always_comb begin
    st_d     = st_q;
    mode_d   = mode_q;
    cs_d     = cs_q;
    sh_d     = sh_q;
    rd_d     = rd_q;
    sel_d    = sel_q;
    err_d    = 1'b0;
    tmr_load = 1'b0;
    tmr_val  = '0;
    res_load = 1'b0;
    case (st_q)
      ST_IDLE: begin
        if (cmd_valid && cmd_ready) begin
          mode_d   = conv_mode_t'(cmd_mode);
          sel_d    = cmd_chan;
          cs_d     = 1'b0;
          tmr_load = 1'b1;
          tmr_val  = LD_SETUP;
          st_d     = ST_SETUP;
        end
      end
      ST_SETUP: begin
        if (tmr_done) begin
          sh_d     = 1'b0;
          tmr_load = 1'b1;
          if (mode_q == MODE_TIED) begin
            rd_d    = 1'b0;
            tmr_val = LD_TMO;
            st_d    = ST_WAIT;
          end else begin
            tmr_val = LD_SHLOW;
            st_d    = ST_SAMPLE;
          end
        end
      end
      ST_SAMPLE: begin
        if (tmr_done) begin
          sh_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_TMO;
          st_d     = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (!int_s) begin
          tmr_load = 1'b1;
          if (mode_q == MODE_TIED) begin
            res_load = 1'b1;
            cs_d     = 1'b1;
            sh_d     = 1'b1;
            rd_d     = 1'b1;
            tmr_val  = LD_GAP;
            st_d     = ST_GAP;
          end else begin
            rd_d    = 1'b0;
            tmr_val = LD_RDLOW;
            st_d    = ST_READ;
          end
        end else if (tmr_done) begin
          err_d    = 1'b1;
          cs_d     = 1'b1;
          sh_d     = 1'b1;
          rd_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_GAP;
          st_d     = ST_GAP;
        end
      end
      ST_READ: begin
        if (tmr_done) begin
          res_load = 1'b1;
          rd_d     = 1'b1;
          cs_d     = 1'b1;
          tmr_load = 1'b1;
          tmr_val  = LD_GAP;
          st_d     = ST_GAP;
        end
      end
      ST_GAP: begin
        if (tmr_done && int_s) st_d = ST_IDLE;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= ST_IDLE;
      mode_q <= MODE_SPLIT;
      cs_q   <= 1'b1;
      sh_q   <= 1'b1;
      rd_q   <= 1'b1;
      sel_q  <= '0;
      err_q  <= 1'b0;
    end else begin
      st_q   <= st_d;
      mode_q <= mode_d;
      cs_q   <= cs_d;
      sh_q   <= sh_d;
      rd_q   <= rd_d;
      sel_q  <= sel_d;
      err_q  <= err_d;
    end
  end

  assign adc_cs_n    = cs_q;
  assign adc_sh_n    = sh_q;
  assign adc_rd_n    = rd_q;
  assign adc_sel     = sel_q;
  assign err_timeout = err_q;
endmodule

// File: rtl/adc_host_ctrl_checker.sv
module adc_host_ctrl_checker #(
  parameter int DATA_W = 10,
  parameter int SEL_W  = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cmd_ready,
  input logic              res_valid,
  input logic              res_ready,
  input logic [DATA_W-1:0] res_data,
  input logic [SEL_W-1:0]  res_chan,
  input logic              err_timeout,
  input logic              adc_cs_n,
  input logic              adc_sh_n,
  input logic              adc_rd_n,
  input logic [SEL_W-1:0]  adc_sel,
  input logic              adc_int_n
);
  AST_SH_GATED_BY_CS: assert property (@(posedge clk) disable iff (rst)
    !adc_sh_n |-> !adc_cs_n); // R2

  AST_RD_GATED_BY_CS: assert property (@(posedge clk) disable iff (rst)
    !adc_rd_n |-> !adc_cs_n); // R2

  AST_SEL_HELD: assert property (@(posedge clk) disable iff (rst)
    (!adc_cs_n && $past(!adc_cs_n)) |-> $stable(adc_sel)); // R3

  AST_READ_AFTER_SYNC: assert property (@(posedge clk) disable iff (rst)
    ($fell(adc_rd_n) && adc_sh_n) |-> (!$past(adc_int_n, 1) && !$past(adc_int_n, 2))); // R10

  AST_TIED_RELEASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(adc_sh_n) && $past(!adc_rd_n)) |-> adc_rd_n); // R6

  AST_RESULT_HELD: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_ready) |=> (res_valid && $stable(res_data) && $stable(res_chan))); // R7

  AST_TIMEOUT_NO_RESULT: assert property (@(posedge clk) disable iff (rst)
    err_timeout |-> (!res_valid && adc_cs_n)); // R8

  AST_READY_QUIET: assert property (@(posedge clk) disable iff (rst)
    cmd_ready |-> (adc_cs_n && adc_sh_n && adc_rd_n)); // R9
endmodule

bind adc_host_ctrl adc_host_ctrl_checker #(.DATA_W(DATA_W), .SEL_W(SEL_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .cmd_ready   (cmd_ready),
  .res_valid   (res_valid),
  .res_ready   (res_ready),
  .res_data    (res_data),
  .res_chan    (res_chan),
  .err_timeout (err_timeout),
  .adc_cs_n    (adc_cs_n),
  .adc_sh_n    (adc_sh_n),
  .adc_rd_n    (adc_rd_n),
  .adc_sel     (adc_sel),
  .adc_int_n   (adc_int_n)
);

// File: tb/adc_host_ctrl_bench.sv
module adc_host_ctrl_bench;
  localparam int DW    = 10;
  localparam int SW    = 2;
  localparam int SETUP = 2;
  localparam int SHL   = 25;
  localparam int RDC   = 3;
  localparam int TMO   = 200;
  localparam int GAP   = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cmd_valid = 1'b0;
  logic cmd_ready;
  logic [SW-1:0] cmd_chan = '0;
  logic cmd_mode = 1'b0;
  logic res_valid;
  logic res_ready = 1'b0;
  logic [DW-1:0] res_data;
  logic [SW-1:0] res_chan;
  logic err_timeout;
  logic adc_cs_n, adc_sh_n, adc_rd_n;
  logic [SW-1:0] adc_sel;
  logic adc_int_n;
  logic [DW-1:0] adc_data;

  adc_host_ctrl #(
    .DATA_W(DW), .SEL_W(SW), .SETUP_CYC(SETUP), .SH_LOW_CYC(SHL),
    .RD_LOW_CYC(RDC), .TIMEOUT_CYC(TMO), .GAP_CYC(GAP), .SYNC_STAGES(2)
  ) u_adc_host_ctrl (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_chan(cmd_chan), .cmd_mode(cmd_mode), .res_valid(res_valid),
    .res_ready(res_ready), .res_data(res_data), .res_chan(res_chan),
    .err_timeout(err_timeout), .adc_cs_n(adc_cs_n), .adc_sh_n(adc_sh_n),
    .adc_rd_n(adc_rd_n), .adc_sel(adc_sel), .adc_int_n(adc_int_n),
    .adc_data(adc_data)
  );

  initial forever #5 clk = ~clk;

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int n_checks = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  // event log filled by the monitor at each falling edge
  int cs_fall_c, cs_rise_c, sh_fall_c, sh_rise_c, rd_fall_c, rd_rise_c;
  int int_fall_c, int_rise_c, resv_c, err_c;
  logic [SW-1:0] sel_at_sh;
  bit cs_viol, sel_viol, split_overlap, tie_viol, tied_expect;
  // converter model controls
  int model_conv1 = 60;
  int model_conv2 = 85;
  int int_up_delay = 2;
  bit model_silent = 1'b0;
  logic [DW-1:0] model_next = '0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // converter model and pin monitor
  initial begin
    int conv_cnt = 0;
    int up_cnt = 0;
    logic p_cs = 1'b1, p_sh = 1'b1, p_rd = 1'b1, p_rv = 1'b0;
    logic [SW-1:0] p_sel = '0;
    adc_int_n = 1'b1;
    adc_data  = '0;
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (p_cs && !adc_cs_n) cs_fall_c = cyc;
        if (!p_cs && adc_cs_n) cs_rise_c = cyc;
        if (p_sh && !adc_sh_n) begin
          sh_fall_c = cyc;
          sel_at_sh = adc_sel;
          if (!adc_rd_n) conv_cnt = model_conv2;
        end
        if (!p_sh && adc_sh_n) begin
          sh_rise_c = cyc;
          if (p_rd) conv_cnt = model_conv1;
        end
        if (p_rd && !adc_rd_n) rd_fall_c = cyc;
        if (!p_rd && adc_rd_n) begin
          rd_rise_c = cyc;
          up_cnt = int_up_delay;
        end
        if (!p_rv && res_valid) resv_c = cyc;
        if (err_timeout) err_c = cyc;
        if (adc_cs_n && (!adc_sh_n || !adc_rd_n)) cs_viol = 1'b1;
        if (!p_cs && !adc_cs_n && adc_sel != p_sel) sel_viol = 1'b1;
        if (!tied_expect && !adc_sh_n && !adc_rd_n) split_overlap = 1'b1;
        if (tied_expect && adc_sh_n != adc_rd_n) tie_viol = 1'b1;
        if (conv_cnt > 0) begin
          conv_cnt--;
          if (conv_cnt == 0 && !model_silent) begin
            adc_int_n  = 1'b0;
            adc_data   = model_next;
            int_fall_c = cyc;
          end
        end
        if (up_cnt > 0) begin
          up_cnt--;
          if (up_cnt == 0) begin
            adc_int_n  = 1'b1;
            int_rise_c = cyc;
          end
        end
      end
      p_cs = adc_cs_n; p_sh = adc_sh_n; p_rd = adc_rd_n;
      p_rv = res_valid; p_sel = adc_sel;
    end
  end

  task automatic clear_flags(input bit tied);
    tied_expect = tied;
    cs_viol = 1'b0; sel_viol = 1'b0; split_overlap = 1'b0; tie_viol = 1'b0;
  endtask

  task automatic issue(input bit mode, input logic [SW-1:0] chan);
    cmd_mode  = mode;
    cmd_chan  = chan;
    cmd_valid = 1'b1;
    while (!cmd_ready) @(negedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
  endtask

  task automatic wait_result(output bit got);
    int n = 0;
    while (!res_valid && n < 2000) begin
      @(negedge clk);
      n++;
    end
    got = res_valid;
  endtask

  task automatic take_result();
    res_ready = 1'b1;
    @(negedge clk);
    res_ready = 1'b0;
    chk(!res_valid, "R7 valid drops after ready", int'(res_valid), 0);
  endtask

  task automatic test_reset();
    chk(adc_cs_n && adc_sh_n && adc_rd_n, "R1 strobes high",
        int'({adc_cs_n, adc_sh_n, adc_rd_n}), 7);
    chk(!res_valid, "R1 res_valid low", int'(res_valid), 0);
    chk(!err_timeout, "R1 err low", int'(err_timeout), 0);
    chk(cmd_ready, "R1 cmd_ready high", int'(cmd_ready), 1);
  endtask

  task automatic test_split(input logic [SW-1:0] chan, input logic [DW-1:0] val);
    bit got;
    logic [DW-1:0] held;
    clear_flags(1'b0);
    model_next = val;
    issue(1'b0, chan);
    wait_result(got);
    chk(got, "R7 split result arrives", int'(got), 1);
    held = res_data;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk(res_valid && res_data == held && !cmd_ready, "R7 result held, no new command",
          int'(res_data), int'(held));
    end
    chk(res_data == val, "R5 split data", int'(res_data), int'(val));
    chk(res_chan == chan, "R7 channel tag", int'(res_chan), int'(chan));
    chk(sel_at_sh == chan, "R3 select at sample edge", int'(sel_at_sh), int'(chan));
    chk(sh_fall_c - cs_fall_c >= SETUP, "R3 setup before sample",
        sh_fall_c - cs_fall_c, SETUP);
    chk(!sel_viol, "R3 select stable", int'(sel_viol), 0);
    chk(sh_rise_c - sh_fall_c == SHL, "R4 sample width", sh_rise_c - sh_fall_c, SHL);
    chk(!split_overlap, "R4 no read during sample", int'(split_overlap), 0);
    chk(rd_fall_c - int_fall_c == 3, "R10 read fall after sync", rd_fall_c - int_fall_c, 3);
    chk(rd_rise_c - rd_fall_c == RDC, "R5 read width", rd_rise_c - rd_fall_c, RDC);
    chk(!cs_viol, "R2 strobes gated by cs", int'(cs_viol), 0);
    take_result();
  endtask

  task automatic test_tied(input logic [SW-1:0] chan, input logic [DW-1:0] val);
    bit got;
    logic [DW-1:0] stale;
    stale = adc_data;
    clear_flags(1'b1);
    model_next = val;
    issue(1'b1, chan);
    wait_result(got);
    chk(got, "R6 tied result arrives", int'(got), 1);
    repeat (2) @(negedge clk);
    chk(res_data == val && val != stale, "R6 new word, not stale bus",
        int'(res_data), int'(val));
    chk(res_chan == chan, "R7 tied channel tag", int'(res_chan), int'(chan));
    chk(!tie_viol, "R6 strobes move together", int'(tie_viol), 0);
    chk(sh_rise_c == rd_rise_c, "R6 common release", sh_rise_c, rd_rise_c);
    chk(resv_c - int_fall_c == 3, "R10 valid after sync", resv_c - int_fall_c, 3);
    chk(sel_at_sh == chan, "R3 tied select", int'(sel_at_sh), int'(chan));
    chk(!cs_viol, "R2 tied strobes gated", int'(cs_viol), 0);
    take_result();
    tied_expect = 1'b0;
  endtask

  task automatic test_timeout();
    int n = 0;
    clear_flags(1'b0);
    err_c = -1;
    model_silent = 1'b1;
    issue(1'b0, 2'd1);
    while (err_c < 0 && n < 1000) begin
      @(negedge clk);
      n++;
    end
    chk(err_c >= 0, "R8 timeout flagged", err_c, 0);
    chk(err_c - sh_rise_c == TMO, "R8 timeout window", err_c - sh_rise_c, TMO);
    @(negedge clk);
    chk(!err_timeout, "R8 single-cycle error", int'(err_timeout), 0);
    chk(adc_cs_n && adc_sh_n && adc_rd_n, "R8 strobes released",
        int'({adc_cs_n, adc_sh_n, adc_rd_n}), 7);
    repeat (20) @(negedge clk);
    chk(!res_valid, "R8 no result", int'(res_valid), 0);
    model_silent = 1'b0;
  endtask

  task automatic test_gap();
    bit got;
    int first_rise;
    clear_flags(1'b0);
    int_up_delay = 20;
    model_next = 10'h0F0;
    res_ready = 1'b1;
    issue(1'b0, 2'd2);
    wait_result(got);
    @(negedge clk);
    first_rise = cs_rise_c;
    model_next = 10'h30F;
    issue(1'b0, 2'd3);
    @(negedge clk);
    chk(cs_fall_c - first_rise >= GAP, "R9 minimum gap", cs_fall_c - first_rise, GAP);
    chk(cs_fall_c - int_rise_c >= 3, "R9 waits for interrupt high",
        cs_fall_c - int_rise_c, 3);
    wait_result(got);
    chk(got && res_data == 10'h30F, "R5 back-to-back data", int'(res_data), 'h30F);
    @(negedge clk);
    res_ready = 1'b0;
    int_up_delay = 2;
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1'b1;
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  endtask

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    test_reset();
    test_split(2'd0, 10'h123);
    test_split(2'd3, 10'h3FF);
    test_tied(2'd2, 10'h000);
    test_tied(2'd1, 10'h2AA);
    test_timeout();
    test_gap();
    test_split(2'd1, 10'h000);
    repeat (5) @(negedge clk);
    report();
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog all requirements actual=hung expected=finish");
    report();
  end
endmodule